// File: doc/BRIEF.md
# CAN Acceptance Filter Bank

This block decides whether a received CAN 2.0B frame is kept and, if so, which message object takes it. The receiver hands over the frame fields already decoded and in parallel: the 29-bit identifier, the frame-format flag (1 = extended) and the first two data bytes. These come with a single-cycle valid strobe. From these fields the block builds a 30-bit screener word. Every one of the filter objects compares that word with its own programmed match word. Mask bits that are set exclude their positions from the comparison. The format flag always has to agree exactly.

For an extended frame the screener is the full identifier followed by the format flag. For a standard frame the screener is the 11-bit identifier with both data bytes appended, so objects can also select on payload content. One clock after the strobe the block reports a result strobe, a hit flag and the index of the winning object. When several objects match, the lowest index wins. When nothing matches, the frame is to be dropped.

Software reaches the match and mask values through a word-addressed 16-bit register bus. Each object has four words. A separate per-object enable register, cleared by reset, keeps unprogrammed objects out of the contest.

Top module: `can_accept_bank`

## Requirements
- R1: Extended frame (`frm_ext`=1): screener bits 29..1 are `frm_id[28:0]` and bit 0 is 1; an enabled object whose match word equals them, with mask 0, hits.
- R2: Standard frame (`frm_ext`=0): screener bits 29..1 are `frm_id[28:18]`, `frm_data1`, `frm_data2`, then two zero positions; bit 0 is 0. `frm_id[17:0]` has no effect.
- R3: A mask bit of 1 makes its screener position don't-care. A mask bit of 0 requires the screener bit to equal the match bit.
- R4: The object's format bit must equal the frame's format flag for a hit, whatever the mask holds.
- R5: When several enabled objects match, `res_idx` gives the lowest-numbered one (0 to NUM_OBJ-1).
- R6: `res_valid` is high exactly in the cycle after `frm_valid`, with `res_hit` and `res_idx` for that frame. `res_hit` is never high without `res_valid`.
- R7: If no enabled object matches, `res_hit` is 0 and `res_idx` is 0.
- R8: The enable register is at word addresses 0x100 (objects 0-15 in bits 0-15) and 0x101 (objects 16-31). It is cleared by synchronous reset, and a disabled object never hits.
- R9: Object n occupies word addresses n*8+0..3 (byte offsets n*16 + 0, 2, 4, 6). Word 0 holds match bits 28..13. Word 1 holds match bits 12..0 in bits 15..3 and the format bit in bit 2, with bits 1..0 reading 0. Word 2 holds mask bits 28..13. Word 3 holds mask bits 12..0 in bits 15..3, with bits 2..0 reading 0.
- R10: Word addresses n*8+4..7 and enable-region words above 0x101 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 9 | Register word address (byte offset / 2) |
| bus_wen | input | 1 | Write strobe for one 16-bit word |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| frm_valid | input | 1 | One-cycle strobe: frame fields valid |
| frm_ext | input | 1 | Frame format flag, 1 = extended |
| frm_id | input | 29 | Identifier; standard frames use bits 28..18 |
| frm_data1 | input | 8 | First data byte |
| frm_data2 | input | 8 | Second data byte |
| res_valid | output | 1 | Result strobe, one cycle after `frm_valid` |
| res_hit | output | 1 | An enabled object accepted the frame |
| res_idx | output | 5 | Index of the accepting object |

## Verification
The bench builds the block with its default of 32 objects, so the reachable indices span the full five-bit range and both enable words are live. With these values it can check that object 31 wins once every lower candidate is disabled, and that enables in the upper word behave like those in the lower word. It also exercises the empty space inside each object's eight-word slot. The reference model checks every result strobe against frames sent in both formats, with the relevant masks either empty or full.

// File: rtl/can_flt_pkg.sv
package can_flt_pkg;

    localparam int BODY_W = 29;

    typedef struct packed {
        logic [BODY_W-1:0] body;
        logic              ext;
    } screener_t;

    typedef struct packed {
        logic [BODY_W-1:0] mid;
        logic              mide;
        logic [BODY_W-1:0] msk;
    } filt_obj_t;

    typedef enum logic [2:0] {
        SEL_MATCH_HI = 3'd0,
        SEL_MATCH_LO = 3'd1,
        SEL_MASK_HI  = 3'd2,
        SEL_MASK_LO  = 3'd3,
        SEL_NONE     = 3'd4
    } reg_sel_e;

    function automatic reg_sel_e decode_sel(input logic [2:0] w);
        case (w)
            3'd0:    return SEL_MATCH_HI;
            3'd1:    return SEL_MATCH_LO;
            3'd2:    return SEL_MASK_HI;
            3'd3:    return SEL_MASK_LO;
            default: return SEL_NONE;
        endcase
    endfunction

    // Standard frames carry the payload bytes where extended ones carry
    // the low identifier bits; two spare positions are tied to zero.
    function automatic screener_t build_screener(input logic ext,
                                                 input logic [28:0] id,
                                                 input logic [7:0] d1,
                                                 input logic [7:0] d2);
        screener_t s;
        s.ext  = ext;
        s.body = ext ? id : {id[28:18], d1, d2, 2'b00};
        return s;
    endfunction

    function automatic logic obj_accepts(input filt_obj_t o,
                                         input logic en,
                                         input screener_t s);
        return en && (o.mide == s.ext) &&
               (((s.body ^ o.mid) & ~o.msk) == '0);
    endfunction

endpackage

// File: rtl/cflt_regs.sv
module cflt_regs
    import can_flt_pkg::*;
#(
    parameter int NUM_OBJ = 32,
    localparam int IDX_W  = $clog2(NUM_OBJ),
    localparam int ADDR_W = IDX_W + 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_wen,
    input  logic [15:0]                 bus_wdata,
    output logic [15:0]                 bus_rdata,
    output filt_obj_t [NUM_OBJ-1:0]     objs_o,
    output logic [NUM_OBJ-1:0]          en_o
);
    localparam int EN_WORDS = NUM_OBJ / 16;

    filt_obj_t [NUM_OBJ-1:0] objs_q;
    logic [NUM_OBJ-1:0]      en_q;

    logic             region_en;
    logic [IDX_W-1:0] obj_sel;
    reg_sel_e         sel;
    logic [IDX_W+2:0] en_word;

    assign region_en = bus_addr[ADDR_W-1];
    assign obj_sel   = bus_addr[IDX_W+2:3];
    assign sel       = decode_sel(bus_addr[2:0]);
    assign en_word   = bus_addr[IDX_W+2:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (bus_wen && region_en) begin
            for (int w = 0; w < EN_WORDS; w++) begin
                if (int'(en_word) == w) en_q[w*16 +: 16] <= bus_wdata;
            end
        end
    end

    // Match and mask contents are left undefined by reset on purpose.
    always_ff @(posedge clk) begin
        if (bus_wen && !region_en) begin
            case (sel)
                SEL_MATCH_HI: objs_q[obj_sel].mid[28:13] <= bus_wdata;
                SEL_MATCH_LO: begin
                    objs_q[obj_sel].mid[12:0] <= bus_wdata[15:3];
                    objs_q[obj_sel].mide      <= bus_wdata[2];
                end
                SEL_MASK_HI:  objs_q[obj_sel].msk[28:13] <= bus_wdata;
                SEL_MASK_LO:  objs_q[obj_sel].msk[12:0]  <= bus_wdata[15:3];
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (region_en) begin
            for (int w = 0; w < EN_WORDS; w++) begin
                if (int'(en_word) == w) bus_rdata = en_q[w*16 +: 16];
            end
        end else begin
            case (sel)
                SEL_MATCH_HI: bus_rdata = objs_q[obj_sel].mid[28:13];
                SEL_MATCH_LO: bus_rdata = {objs_q[obj_sel].mid[12:0],
                                           objs_q[obj_sel].mide, 2'b00};
                SEL_MASK_HI:  bus_rdata = objs_q[obj_sel].msk[28:13];
                SEL_MASK_LO:  bus_rdata = {objs_q[obj_sel].msk[12:0], 3'b000};
                default:      bus_rdata = '0;
            endcase
        end
    end

    assign objs_o = objs_q;
    assign en_o   = en_q;

endmodule

// File: rtl/cflt_match.sv
module cflt_match
    import can_flt_pkg::*;
#(
    parameter int NUM_OBJ = 32
) (
    input  screener_t               scr_i,
    input  filt_obj_t [NUM_OBJ-1:0] objs_i,
    input  logic [NUM_OBJ-1:0]      en_i,
    output logic [NUM_OBJ-1:0]      hit_o
);
    for (genvar g = 0; g < NUM_OBJ; g++) begin : g_obj
        assign hit_o[g] = obj_accepts(objs_i[g], en_i[g], scr_i);
    end
endmodule

// File: rtl/cflt_pick.sv
module cflt_pick #(
    parameter int NUM_OBJ = 32,
    localparam int IDX_W  = $clog2(NUM_OBJ)
) (
    input  logic [NUM_OBJ-1:0] hit_i,
    output logic               any_o,
    output logic [IDX_W-1:0]   idx_o
);
    logic [NUM_OBJ-1:0] sel_onehot;
    logic [NUM_OBJ-1:0] below;

    always_comb begin
        any_o = |hit_i;
        idx_o = '0;
        for (int i = NUM_OBJ - 1; i >= 0; i--) begin
            if (hit_i[i]) idx_o = IDX_W'(i);
        end
    end

    always_comb begin
        sel_onehot        = '0;
        sel_onehot[idx_o] = 1'b1;
        below             = sel_onehot - 1'b1;
        if (any_o) begin
            assert_lowest_wins_R5: assert (hit_i[idx_o] && ((hit_i & below) == '0))
                else $error("winner is not the lowest matching object");
        end
    end
endmodule

// File: rtl/can_accept_bank.sv
module can_accept_bank
    import can_flt_pkg::*;
#(
    parameter int NUM_OBJ = 32,
    localparam int IDX_W  = $clog2(NUM_OBJ),
    localparam int ADDR_W = IDX_W + 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic              frm_valid,
    input  logic              frm_ext,
    input  logic [28:0]       frm_id,
    input  logic [7:0]        frm_data1,
    input  logic [7:0]        frm_data2,
    output logic              res_valid,
    output logic              res_hit,
    output logic [IDX_W-1:0]  res_idx
);
    filt_obj_t [NUM_OBJ-1:0] objs;
    logic [NUM_OBJ-1:0]      en_vec;
    logic [NUM_OBJ-1:0]      hit_vec;
    logic [NUM_OBJ-1:0]      mide_vec;
    logic                    any_hit;
    logic [IDX_W-1:0]        win_idx;
    screener_t               scr;

    assign scr = build_screener(frm_ext, frm_id, frm_data1, frm_data2);

    cflt_regs #(.NUM_OBJ(NUM_OBJ)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wen   (bus_wen),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .objs_o    (objs),
        .en_o      (en_vec)
    );

    cflt_match #(.NUM_OBJ(NUM_OBJ)) u_match (
        .scr_i  (scr),
        .objs_i (objs),
        .en_i   (en_vec),
        .hit_o  (hit_vec)
    );

    cflt_pick #(.NUM_OBJ(NUM_OBJ)) u_pick (
        .hit_i (hit_vec),
        .any_o (any_hit),
        .idx_o (win_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_idx   <= '0;
        end else begin
            res_valid <= frm_valid;
            res_hit   <= frm_valid && any_hit;
            res_idx   <= (frm_valid && any_hit) ? win_idx : '0;
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_OBJ; i++) mide_vec[i] = objs[i].mide;
    end

    assert_strobe_follows_R6: assert property (@(posedge clk) disable iff (rst)
        frm_valid |=> res_valid);
    assert_no_stray_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        !frm_valid |=> !res_valid);
    assert_hit_needs_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        res_hit |-> res_valid);
    assert_miss_index_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_hit) |-> (res_idx == '0));
    assert_winner_enabled_R8: assert property (@(posedge clk) disable iff (rst)
        res_hit |-> ((($past(en_vec) >> res_idx) & NUM_OBJ'(1)) != '0));
    assert_format_exact_R4: assert property (@(posedge clk) disable iff (rst)
        res_hit |-> (((($past(mide_vec) >> res_idx) & NUM_OBJ'(1)) != '0)
                     == $past(frm_ext)));

endmodule

// File: tb/can_accept_bank_test.sv
`timescale 1ns/100ps
module can_accept_bank_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [8:0]  bus_addr = '0;
    logic        bus_wen = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        frm_valid = 1'b0;
    logic        frm_ext = 1'b0;
    logic [28:0] frm_id = '0;
    logic [7:0]  frm_data1 = '0;
    logic [7:0]  frm_data2 = '0;
    logic        res_valid;
    logic        res_hit;
    logic [4:0]  res_idx;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    can_accept_bank uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frm_valid(frm_valid),
        .frm_ext(frm_ext), .frm_id(frm_id), .frm_data1(frm_data1),
        .frm_data2(frm_data2), .res_valid(res_valid), .res_hit(res_hit),
        .res_idx(res_idx)
    );

    // Behavioural reference: register words kept as software sees them.
    logic [15:0] m_mh [32];
    logic [15:0] m_ml [32];
    logic [15:0] m_kh [32];
    logic [15:0] m_kl [32];
    logic [31:0] m_en = '0;
    logic        e_valid = 0, e_hit = 0;
    logic [4:0]  e_idx = 0;
    bit          cmp_on = 0;

    initial begin
        for (int i = 0; i < 32; i++) begin
            m_mh[i] = 0; m_ml[i] = 0; m_kh[i] = 0; m_kl[i] = 0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic void ref_eval(input logic ext, input logic [28:0] id,
                                     input logic [7:0] d1, input logic [7:0] d2,
                                     output logic hit, output logic [4:0] idx);
        logic [29:0] s;
        logic [28:0] mid, msk;
        s = ext ? {id, 1'b1} : {id[28:18], d1, d2, 2'b00, 1'b0};
        hit = 0; idx = 0;
        for (int i = 0; i < 32; i++) begin
            mid = {m_mh[i], m_ml[i][15:3]};
            msk = {m_kh[i], m_kl[i][15:3]};
            if (!hit && m_en[i] && (m_ml[i][2] == s[0]) &&
                (((s[29:1] ^ mid) & ~msk) == 0)) begin
                hit = 1; idx = 5'(i);
            end
        end
    endfunction

    always @(negedge clk) begin
        logic h; logic [4:0] x;
        if (cmp_on) begin
            chk("R6 model strobe", res_valid, e_valid);
            chk("R6 model hit", res_hit, e_hit);
            chk("R6 model index", res_idx, e_idx);
        end
        if (rst) begin
            cmp_on = 1;
            m_en = 0; e_valid = 0; e_hit = 0; e_idx = 0;
        end else begin
            ref_eval(frm_ext, frm_id, frm_data1, frm_data2, h, x);
            e_valid = frm_valid;
            e_hit = frm_valid && h;
            e_idx = (frm_valid && h) ? x : 5'd0;
            if (bus_wen) begin
                if (!bus_addr[8]) begin
                    case (bus_addr[2:0])
                        3'd0: m_mh[bus_addr[7:3]] = bus_wdata;
                        3'd1: m_ml[bus_addr[7:3]] = bus_wdata & 16'hFFFC;
                        3'd2: m_kh[bus_addr[7:3]] = bus_wdata;
                        3'd3: m_kl[bus_addr[7:3]] = bus_wdata & 16'hFFF8;
                        default: ;
                    endcase
                end else if (bus_addr[7:0] == 0) m_en[15:0] = bus_wdata;
                else if (bus_addr[7:0] == 1) m_en[31:16] = bus_wdata;
            end
        end
    end

    task automatic wr(input logic [8:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wen = 1;
        @(posedge clk); #1;
        bus_wen = 0;
    endtask

    task automatic rd_chk(input logic [8:0] a, input logic [15:0] exp, input string tag);
        @(posedge clk); #1;
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic frame(input logic ext, input logic [28:0] id,
                         input logic [7:0] d1, input logic [7:0] d2);
        @(posedge clk); #1;
        frm_valid = 1; frm_ext = ext; frm_id = id; frm_data1 = d1; frm_data2 = d2;
        @(posedge clk); #1;
        frm_valid = 0;
    endtask

    task automatic res_chk(input logic hit, input logic [4:0] idx, input string tag);
        chk({tag, " strobe"}, res_valid, 1'b1);
        chk({tag, " hit"}, res_hit, hit);
        chk({tag, " index"}, res_idx, idx);
    endtask

    task automatic prog(input int n, input logic [28:0] mid, input logic mide,
                        input logic [28:0] msk);
        wr(9'(n*8+0), mid[28:13]);
        wr(9'(n*8+1), {mid[12:0], mide, 2'b00});
        wr(9'(n*8+2), msk[28:13]);
        wr(9'(n*8+3), {msk[12:0], 3'b000});
    endtask

    localparam logic [28:0] XID = 29'h1ABCDE12;
    localparam logic [28:0] SID = {11'h5A3, 18'h0};
    localparam logic [28:0] SBODY = {11'h5A3, 8'h3C, 8'hC5, 2'b00};

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        #1;
        chk("R6 reset strobe", res_valid, 0);
        chk("R7 reset hit", res_hit, 0);
        rd_chk(9'h100, 16'h0000, "R8 enable low after reset");
        rd_chk(9'h101, 16'h0000, "R8 enable high after reset");

        // R1/R8: extended object 3, exact match, first disabled
        prog(3, XID, 1'b1, 29'h0);
        frame(1, XID, 8'h00, 8'h00);
        res_chk(0, 0, "R8 disabled object");
        wr(9'h100, 16'h0008);
        frame(1, XID, 8'h11, 8'h22);
        res_chk(1, 3, "R1 extended exact");
        @(posedge clk); #1;
        chk("R6 strobe one cycle only", res_valid, 0);
        frame(1, XID ^ 29'h1, 8'h00, 8'h00);
        res_chk(0, 0, "R7 extended miss");

        // R3: mask out identifier bit 0 only
        wr(9'(3*8+3), 16'h0008);
        frame(1, XID ^ 29'h1, 8'h00, 8'h00);
        res_chk(1, 3, "R3 masked bit");
        frame(1, XID ^ 29'h2, 8'h00, 8'h00);
        res_chk(0, 0, "R3 unmasked bit");

        // R4: everything masked, format must still agree
        wr(9'(3*8+2), 16'hFFFF);
        wr(9'(3*8+3), 16'hFFFF);
        frame(0, SID, 8'h3C, 8'hC5);
        res_chk(0, 0, "R4 format mismatch");
        frame(1, 29'h0F0F0F0F, 8'h00, 8'h00);
        res_chk(1, 3, "R3 fully masked");

        // R2: standard object 5 selecting on both payload bytes
        prog(5, SBODY, 1'b0, 29'h0);
        wr(9'h100, 16'h0028);
        frame(0, SID, 8'h3C, 8'hC5);
        res_chk(1, 5, "R2 standard with payload");
        frame(0, SID, 8'h3C, 8'hC4);
        res_chk(0, 0, "R2 second byte differs");
        frame(0, SID | 29'h3FFFF, 8'h3C, 8'hC5);
        res_chk(1, 5, "R2 low identifier bits ignored");

        // R5: several candidates
        prog(7, 29'h0, 1'b0, 29'h1FFFFFFF);
        prog(31, 29'h0, 1'b0, 29'h1FFFFFFF);
        wr(9'h100, 16'h00A8);
        wr(9'h101, 16'h8000);
        frame(0, SID, 8'h3C, 8'h00);
        res_chk(1, 7, "R5 lowest of two");
        frame(0, SID, 8'h3C, 8'hC5);
        res_chk(1, 5, "R5 lowest of three");
        wr(9'h100, 16'h0028);
        frame(0, SID, 8'h3C, 8'h00);
        res_chk(1, 31, "R5 top index after disable");

        // R9: register layout
        rd_chk(9'(3*8+0), XID[28:13], "R9 match high");
        rd_chk(9'(3*8+1), {XID[12:0], 1'b1, 2'b00}, "R9 match low");
        wr(9'(9*8+1), 16'hFFFF);
        rd_chk(9'(9*8+1), 16'hFFFC, "R9 match low spare bits");
        wr(9'(9*8+3), 16'hFFFF);
        rd_chk(9'(9*8+3), 16'hFFF8, "R9 mask low spare bits");
        rd_chk(9'(31*8+2), 16'hFFFF, "R9 mask high");
        rd_chk(9'h101, 16'h8000, "R8 enable high readback");

        // R10: unmapped words
        wr(9'(3*8+5), 16'hFFFF);
        rd_chk(9'(3*8+5), 16'h0000, "R10 spare object word");
        rd_chk(9'(3*8+0), XID[28:13], "R10 neighbour untouched");
        wr(9'h102, 16'hBEEF);
        rd_chk(9'h102, 16'h0000, "R10 spare enable word");
        rd_chk(9'h100, 16'h0028, "R10 enable word untouched");

        // R8: reset in the middle clears the enables
        @(posedge clk); #1 rst = 1;
        @(posedge clk); #1 rst = 0;
        rd_chk(9'h100, 16'h0000, "R8 enable cleared by reset");
        frame(0, SID, 8'h3C, 8'hC5);
        res_chk(0, 0, "R8 no hit after reset");

        repeat (3) @(posedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule